// File: doc/BRIEF.md
# Tournament Hybrid Branch Direction Predictor

This block predicts whether a conditional branch is taken. It holds two predictors made of two-bit saturating counters. The first, the local table, is indexed by low program-counter bits alone. The second, the correlated table, is indexed by program-counter bits XORed with a register of recent branch outcomes. A third table of two-bit counters, also indexed by program-counter bits, decides per branch which of the two predictions is returned. The chooser starts every branch on the local table. A branch moves to the correlated table only after the local table has mispredicted it while the correlated table was right.

A fetch stage raises a request with the branch address. One clock later the block returns the chosen direction, both component directions and the history value that was used. The fetch stage keeps these values and hands them back when the branch resolves. The block then trains both component counters and, when the components disagreed, the chooser. The history register is shifted speculatively with each prediction. A resolve that reveals a misprediction rebuilds the history from the returned snapshot and the true outcome.

Top module: `tourn_pred`

## Requirements
- R1: After synchronous reset, every local and correlated counter holds 1 (weak not-taken), every chooser counter holds 0 and the history register is 0, so the first prediction is not-taken from the local table with history 0.
- R2: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high, and the response fields are registered.
- R3: The local prediction reads the counter at index `req_pc[SIMP_IDX_W-1:0]`; a counter value of 2 or 3 means taken.
- R4: The correlated prediction reads the counter at index `req_pc[GLOB_IDX_W-1:0]` XOR the zero-extended history; a value of 2 or 3 means taken.
- R5: Counter encoding is 0 strong not-taken, 1 weak not-taken, 2 weak taken, 3 strong taken. On every update both component counters, at the indices rebuilt from `upd_pc` and `upd_hist`, step up when taken and down when not-taken, saturating at 3 and 0.
- R6: The chooser at `req_pc[CHOOSE_IDX_W-1:0]` selects the correlated prediction when it is 2 or more. It changes only on an update whose two component directions differ: up when the correlated one matched the outcome, down otherwise, saturating at 3 and 0.
- R7: Each accepted request shifts the history left by one with the chosen direction in bit 0. `rsp_hist` shows the history value used for that prediction.
- R8: An update with `upd_final_taken` different from `upd_taken` loads the history with `upd_hist` shifted left with `upd_taken` in bit 0. This repair wins over a speculative shift in the same cycle.
- R9: A request in the same cycle as an update reads the table values from before that update.
- R10: A branch that alternates taken and not-taken, predicted and resolved in turn, ends up served by the correlated table (`rsp_use_glob` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Prediction request |
| req_pc | input | PC_W | Branch address of the request |
| rsp_valid | output | 1 | Response present, one cycle after a request |
| rsp_taken | output | 1 | Chosen direction |
| rsp_use_glob | output | 1 | Chosen direction came from the correlated table |
| rsp_simple_taken | output | 1 | Local table direction |
| rsp_glob_taken | output | 1 | Correlated table direction |
| rsp_hist | output | HIST_W | History used for this prediction |
| upd_valid | input | 1 | Resolved branch update |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | HIST_W | History snapshot returned at prediction |
| upd_taken | input | 1 | True outcome |
| upd_simple_taken | input | 1 | Local direction returned at prediction |
| upd_glob_taken | input | 1 | Correlated direction returned at prediction |
| upd_final_taken | input | 1 | Chosen direction returned at prediction |

## Verification
A response is due one rising edge after its request, so the bench drives on falling edges and compares every response field on the following falling edge. The speculative shift and the repair land on the same edge as the request or update that causes them, so their effect shows in `rsp_hist` of the next request, one edge later. Table writes from an update are seen by requests issued from the next cycle on. A request in the same cycle as an update must still see the older value. The reference model applies reads before writes at each edge, and so keeps the same order.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_STRONG_NT = 2'd0;
  localparam ctr2_t CTR_WEAK_NT   = 2'd1;
  localparam ctr2_t CTR_STRONG_T  = 2'd3;

  // saturating step of a two-bit counter
  function automatic ctr2_t ctr_step(ctr2_t c, logic up);
    if (up) return (c == CTR_STRONG_T) ? c : c + 2'd1;
    else    return (c == CTR_STRONG_NT) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/ctr_table.sv
module ctr_table
  import tp_pkg::*;
#(
  parameter int    IDX_W = 6,
  parameter ctr2_t INIT  = CTR_WEAK_NT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];

  // read is asynchronous: value before any write at this edge
  assign rd_ctr = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_step(mem[wr_idx], wr_up);
    end
  end
endmodule

// File: rtl/ghist_reg.sv
module ghist_reg #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spec_en,
  input  logic              spec_dir,
  input  logic              fix_en,
  input  logic [HIST_W-1:0] fix_base,
  input  logic              fix_dir,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)          hist <= '0;
    else if (fix_en)  hist <= {fix_base[HIST_W-2:0], fix_dir};
    else if (spec_en) hist <= {hist[HIST_W-2:0], spec_dir};
  end
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
  import tp_pkg::*;
#(
  parameter int PC_W         = 16,
  parameter int SIMP_IDX_W   = 6,
  parameter int GLOB_IDX_W   = 8,
  parameter int CHOOSE_IDX_W = 6,
  parameter int HIST_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [PC_W-1:0]   req_pc,
  output logic              rsp_valid,
  output logic              rsp_taken,
  output logic              rsp_use_glob,
  output logic              rsp_simple_taken,
  output logic              rsp_glob_taken,
  output logic [HIST_W-1:0] rsp_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken,
  input  logic              upd_simple_taken,
  input  logic              upd_glob_taken,
  input  logic              upd_final_taken
);
  logic [HIST_W-1:0] hist;

  // index formation
  logic [SIMP_IDX_W-1:0]   s_rd_idx, s_wr_idx;
  logic [GLOB_IDX_W-1:0]   g_rd_idx, g_wr_idx;
  logic [CHOOSE_IDX_W-1:0] c_rd_idx, c_wr_idx;

  assign s_rd_idx = req_pc[SIMP_IDX_W-1:0];
  assign s_wr_idx = upd_pc[SIMP_IDX_W-1:0];
  assign g_rd_idx = req_pc[GLOB_IDX_W-1:0] ^ GLOB_IDX_W'(hist);
  assign g_wr_idx = upd_pc[GLOB_IDX_W-1:0] ^ GLOB_IDX_W'(upd_hist);
  assign c_rd_idx = req_pc[CHOOSE_IDX_W-1:0];
  assign c_wr_idx = upd_pc[CHOOSE_IDX_W-1:0];

  ctr2_t s_ctr, g_ctr, c_ctr;
  logic  disagree, glob_right, repair;

  assign disagree   = upd_simple_taken ^ upd_glob_taken;
  assign glob_right = (upd_glob_taken == upd_taken);
  assign repair     = upd_valid && (upd_final_taken != upd_taken);

  ctr_table #(.IDX_W(SIMP_IDX_W), .INIT(CTR_WEAK_NT)) i_simple (
    .clk(clk), .rst(rst), .rd_idx(s_rd_idx), .rd_ctr(s_ctr),
    .wr_en(upd_valid), .wr_idx(s_wr_idx), .wr_up(upd_taken)
  );

  ctr_table #(.IDX_W(GLOB_IDX_W), .INIT(CTR_WEAK_NT)) i_glob (
    .clk(clk), .rst(rst), .rd_idx(g_rd_idx), .rd_ctr(g_ctr),
    .wr_en(upd_valid), .wr_idx(g_wr_idx), .wr_up(upd_taken)
  );

  ctr_table #(.IDX_W(CHOOSE_IDX_W), .INIT(CTR_STRONG_NT)) i_choose (
    .clk(clk), .rst(rst), .rd_idx(c_rd_idx), .rd_ctr(c_ctr),
    .wr_en(upd_valid && disagree), .wr_idx(c_wr_idx), .wr_up(glob_right)
  );

  // prediction
  logic p_simple, p_glob, p_use_glob, p_final;
  assign p_simple   = s_ctr[1];
  assign p_glob     = g_ctr[1];
  assign p_use_glob = c_ctr[1];
  assign p_final    = p_use_glob ? p_glob : p_simple;

  ghist_reg #(.HIST_W(HIST_W)) i_hist (
    .clk(clk), .rst(rst),
    .spec_en(req_valid), .spec_dir(p_final),
    .fix_en(repair), .fix_base(upd_hist), .fix_dir(upd_taken),
    .hist(hist)
  );

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid        <= 1'b0;
      rsp_taken        <= 1'b0;
      rsp_use_glob     <= 1'b0;
      rsp_simple_taken <= 1'b0;
      rsp_glob_taken   <= 1'b0;
      rsp_hist         <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_taken        <= p_final;
        rsp_use_glob     <= p_use_glob;
        rsp_simple_taken <= p_simple;
        rsp_glob_taken   <= p_glob;
        rsp_hist         <= hist;
      end
    end
  end
endmodule

// File: rtl/tourn_pred_chk.sv
module tourn_pred_chk #(
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_taken,
  input logic              rsp_use_glob,
  input logic              rsp_simple_taken,
  input logic              rsp_glob_taken,
  input logic [HIST_W-1:0] rsp_hist,
  input logic              upd_valid,
  input logic [HIST_W-1:0] upd_hist,
  input logic              upd_taken,
  input logic              upd_final_taken
);
  logic fix;
  assign fix = upd_valid && (upd_final_taken != upd_taken);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !rsp_valid);

  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r6_choice_consistent: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_taken == (rsp_use_glob ? rsp_glob_taken : rsp_simple_taken)));

  a_r7_spec_shift: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && req_valid && !$past(fix)) |=>
      (rsp_hist == {$past(rsp_hist[HIST_W-2:0]), $past(rsp_taken)}));

  a_r8_repair: assert property (@(posedge clk) disable iff (rst)
    ($past(fix) && req_valid) |=>
      (rsp_hist == {$past(upd_hist[HIST_W-2:0], 2), $past(upd_taken, 2)}));
endmodule

bind tourn_pred tourn_pred_chk #(.HIST_W(HIST_W)) i_tourn_pred_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_taken(rsp_taken), .rsp_use_glob(rsp_use_glob),
  .rsp_simple_taken(rsp_simple_taken), .rsp_glob_taken(rsp_glob_taken),
  .rsp_hist(rsp_hist), .upd_valid(upd_valid), .upd_hist(upd_hist),
  .upd_taken(upd_taken), .upd_final_taken(upd_final_taken)
);

// File: tb/test_tourn_pred.sv
module test_tourn_pred;
  localparam int PC_W = 16, SW = 6, GW = 8, CW = 6, HW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [PC_W-1:0] req_pc = '0;
  logic rsp_valid, rsp_taken, rsp_use_glob, rsp_simple_taken, rsp_glob_taken;
  logic [HW-1:0] rsp_hist;
  logic upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic [HW-1:0] upd_hist = '0;
  logic upd_taken = 1'b0, upd_simple_taken = 1'b0, upd_glob_taken = 1'b0, upd_final_taken = 1'b0;

  always #2 clk = ~clk;

  tourn_pred #(.PC_W(PC_W), .SIMP_IDX_W(SW), .GLOB_IDX_W(GW),
               .CHOOSE_IDX_W(CW), .HIST_W(HW)) i_tourn_pred (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_pc(req_pc),
    .rsp_valid(rsp_valid), .rsp_taken(rsp_taken), .rsp_use_glob(rsp_use_glob),
    .rsp_simple_taken(rsp_simple_taken), .rsp_glob_taken(rsp_glob_taken),
    .rsp_hist(rsp_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_hist(upd_hist), .upd_taken(upd_taken),
    .upd_simple_taken(upd_simple_taken), .upd_glob_taken(upd_glob_taken),
    .upd_final_taken(upd_final_taken)
  );

  int checks = 0, fails = 0;
  string phase = "R1 reset";

  task automatic chk(string fld, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", phase, fld, act, exp);
    end
  endtask

  // behavioural reference model
  int m_s[1<<SW];
  int m_g[1<<GW];
  int m_c[1<<CW];
  int m_hist;
  int e_valid, e_taken, e_use, e_simple, e_glob, e_hist;

  function automatic int sat(int c, logic up);
    if (up) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_s[i]) m_s[i] = 1;
      foreach (m_g[i]) m_g[i] = 1;
      foreach (m_c[i]) m_c[i] = 0;
      m_hist = 0;
      e_valid = 0;
    end else begin
      e_valid = req_valid;
      if (req_valid) begin
        e_simple = (m_s[req_pc % (1<<SW)] >= 2);
        e_glob   = (m_g[(req_pc % (1<<GW)) ^ m_hist] >= 2);
        e_use    = (m_c[req_pc % (1<<CW)] >= 2);
        e_taken  = e_use ? e_glob : e_simple;
        e_hist   = m_hist;
      end
      if (upd_valid) begin
        int si, gi, ci;
        si = upd_pc % (1<<SW);
        gi = (upd_pc % (1<<GW)) ^ int'(upd_hist);
        ci = upd_pc % (1<<CW);
        m_s[si] = sat(m_s[si], upd_taken);
        m_g[gi] = sat(m_g[gi], upd_taken);
        if (upd_simple_taken != upd_glob_taken)
          m_c[ci] = sat(m_c[ci], upd_glob_taken == upd_taken);
      end
      if (upd_valid && (upd_final_taken != upd_taken))
        m_hist = ((int'(upd_hist) << 1) | int'(upd_taken)) % (1<<HW);
      else if (req_valid)
        m_hist = ((m_hist << 1) | e_taken) % (1<<HW);
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("rsp_valid (R2)", rsp_valid, e_valid);
      if (e_valid) begin
        chk("rsp_simple_taken (R3 R5)", rsp_simple_taken, e_simple);
        chk("rsp_glob_taken (R4 R5)", rsp_glob_taken, e_glob);
        chk("rsp_use_glob (R6)", rsp_use_glob, e_use);
        chk("rsp_taken (R6)", rsp_taken, e_taken);
        chk("rsp_hist (R7 R8)", rsp_hist, e_hist);
      end
    end
  end

  task automatic drive(logic rv, int pc, logic uv, int upc, int uh,
                       logic ut, logic us, logic ug, logic uf);
    @(negedge clk);
    req_valid = rv; req_pc = PC_W'(pc);
    upd_valid = uv; upd_pc = PC_W'(upc); upd_hist = HW'(uh);
    upd_taken = ut; upd_simple_taken = us; upd_glob_taken = ug; upd_final_taken = uf;
  endtask

  // predict one branch, then resolve it on the following cycle
  task automatic pr(int pc, logic taken);
    drive(1, pc, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 1, pc, rsp_hist, taken, rsp_simple_taken, rsp_glob_taken, rsp_taken);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", wd);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: first prediction from reset state
    drive(1, 5, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 first taken", rsp_taken, 0);
    chk("R1 first use_glob", rsp_use_glob, 0);
    chk("R1 first hist", rsp_hist, 0);
    // R2: idle cycles produce no response
    phase = "R2 idle";
    repeat (3) drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 R5: saturation up then down on one branch
    phase = "R3 R5 saturation";
    repeat (5) pr(3, 1);
    repeat (5) pr(3, 0);
    // R4: aliasing local index, distinct correlated index
    phase = "R4 xor index";
    pr(3, 1); pr(67, 0); pr(3, 1); pr(67, 1); pr(131, 0);
    // R7: back-to-back speculative requests
    phase = "R7 spec shift";
    for (int i = 0; i < 6; i++) drive(1, 3 + 4*i, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: repair in the same cycle as a request
    phase = "R8 repair";
    drive(1, 11, 1, 11, 8'h5A, 1, 0, 0, 0);
    drive(1, 12, 0, 0, 0, 0, 0, 0, 0);
    drive(1, 13, 1, 13, 8'h0F, 0, 1, 1, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9: request and update on the same entry in one cycle
    phase = "R9 read before write";
    drive(1, 3, 1, 3, 0, 1, 1, 0, 1);
    drive(1, 3, 1, 3, 0, 1, 1, 0, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6 R10: alternating branch migrates to the correlated table
    phase = "R6 R10 alternating";
    for (int i = 0; i < 80; i++) pr(9, logic'(i % 2));
    drive(1, 9, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 use_glob after training", rsp_use_glob, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule